// File: doc/BRIEF.md
# Configuration-Port I/O Decoder

This block sits in a host bridge and answers CPU I/O-port cycles that software uses to reach configuration space. It turns those cycles into single configuration read or write requests, each carrying bus, device, function, dword register index, byte enables and write data. A strap input selects one of two legacy access methods.

In the latch method, software writes a 32-bit target address into an address latch and then uses a data window. In the paged method, software writes an enable byte and a forward byte (the target bus), and a 4 KiB I/O range then maps straight onto configuration space. Claimed I/O cycles are held with a ready pulse until the configuration request completes, and only one request is outstanding at a time. When the window is closed, reads return all ones and writes are dropped.

The I/O side uses a dword address: the byte address with its two low bits removed, plus four byte-lane enables.

Top module: `cfgport_decoder`

## Requirements
- R1: After reset, io_ready and cfg_req_valid are low, the address latch reads 0, and the enable and forward bytes read 0.
- R2: Latch method (mech_sel=0): a write to byte address 0x0CF8 with all four byte enables set stores the latch. A read returns the written value ANDed with 0x80FFFFFC, so bits 30:24 and 1:0 read 0.
- R3: Latch method: a write to 0x0CF8–0x0CFB whose byte enables are not all set is completed, but it leaves the latch unchanged.
- R4: Latch method: with latch bit 31 set, an access to 0x0CFC issues one configuration request. The request takes bus from latch bits 23:16, device from 15:11, function from 10:8 and register index from 7:2, and passes the access's write flag, byte enables and data. A read returns cfg_rdata.
- R5: Paged method (mech_sel=1): at dword 0x0CF8, byte lane 0 is the enable byte and byte lane 2 (port 0x0CFA) is the forward byte. Each is written only when its lane enable is set. A read returns {8'h00, forward, 8'h00, enable}.
- R6: Paged method: with enable bits 7:4 equal to 0xF, an access to byte addresses 0xC000–0xCFFF issues a request. Its fields are bus = forward byte, device = address bits 11:8 (device bit 4 is always 0), function = enable bits 3:1, and register index = address bits 7:2.
- R7: When the window is closed (latch bit 31 clear, or enable bits 7:4 not 0xF, including after a zero is written to the enable byte), a window access issues no request, reads as 0xFFFFFFFF, and its write is discarded.
- R8: Only the selected method's ports are claimed. An access to the other method's window, or to any other address, gets no io_ready and no request.
- R9: io_ready is a one-cycle pulse for each claimed access. It comes in the cycle after the strobe for register and closed-window accesses, and in the cycle after cfg_ack for requests. Request fields stay stable while cfg_req_valid waits for cfg_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mech_sel | input | 1 | Strap: 0 latch method, 1 paged method |
| io_strobe | input | 1 | I/O cycle request, held until io_ready |
| io_wr | input | 1 | 1 write, 0 read |
| io_addr | input | 14 | I/O dword address (byte address bits 15:2) |
| io_be | input | 4 | Byte-lane enables |
| io_wdata | input | 32 | I/O write data |
| io_ready | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | I/O read data, valid with io_ready |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Request byte enables |
| cfg_wdata | output | 32 | Request write data |
| cfg_ack | input | 1 | Request completion |
| cfg_rdata | input | 32 | Request read data, valid with cfg_ack |

## Verification
The assertions check on every cycle that io_ready is a single-cycle pulse that never overlaps a pending request, and that request fields hold while waiting for an acknowledge. They also check that a request only starts from an open window, that the paged method never targets devices 16–31, and that latch read-back always has its reserved bits clear. Only the bench scenarios can show the field mapping from the latch and from the port address, that partial writes leave the latch intact, that each method's registers read back correctly, and that the inactive method's ports go unanswered.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int IO_ADDR_W = 16;
  localparam int DW_ADDR_W = IO_ADDR_W - 2;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FUNC_W    = 3;
  localparam int REG_W     = 6;

  // Latch bits that survive a write: enable, bus, device, function, register
  localparam logic [DATA_W-1:0] LATCH_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_M1_ADDR,
    ACC_M2_REGS,
    ACC_WINDOW
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RESP
  } fsm_e;

  typedef struct packed {
    logic              write;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  regi;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] wdata;
  } cfg_req_t;
endpackage

// File: rtl/cfgport_m1_latch.sv
module cfgport_m1_latch
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '0;
    else if (wr_en) latch_q <= wr_data & LATCH_KEEP;
  end
endmodule

// File: rtl/cfgport_m2_regs.sv
module cfgport_m2_regs
  import cfgport_pkg::*;
#(
  parameter int EN_LANE  = 0,
  parameter int FWD_LANE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        en_q,
  output logic [7:0]        fwd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      fwd_q <= '0;
    end else if (wr_en) begin
      if (wr_be[EN_LANE])  en_q  <= wr_data[EN_LANE*8 +: 8];
      if (wr_be[FWD_LANE]) fwd_q <= wr_data[FWD_LANE*8 +: 8];
    end
  end
endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] M1_ADDR_PORT = 16'h0CF8,
  parameter logic [IO_ADDR_W-1:0] M1_DATA_PORT = 16'h0CFC,
  parameter logic [IO_ADDR_W-1:0] M2_WIN_BASE  = 16'hC000
) (
  input  logic                 mech_sel,
  input  logic [DW_ADDR_W-1:0] dw_addr,
  input  logic                 wr,
  input  logic [BE_W-1:0]      be,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    latch,
  input  logic [7:0]           en,
  input  logic [7:0]           fwd,
  output acc_kind_e            kind,
  output logic                 win_open,
  output cfg_req_t             req
);
  localparam logic [DW_ADDR_W-1:0] M1A_DW = M1_ADDR_PORT[IO_ADDR_W-1:2];
  localparam logic [DW_ADDR_W-1:0] M1D_DW = M1_DATA_PORT[IO_ADDR_W-1:2];
  localparam logic [3:0]           M2_PAGE = M2_WIN_BASE[IO_ADDR_W-1 -: 4];

  always_comb begin
    kind      = ACC_NONE;
    win_open  = 1'b0;
    req       = '0;
    req.write = wr;
    req.be    = be;
    req.wdata = wdata;
    if (!mech_sel) begin
      if (dw_addr == M1A_DW)      kind = ACC_M1_ADDR;
      else if (dw_addr == M1D_DW) kind = ACC_WINDOW;
      win_open = latch[31];
      req.bus  = latch[23:16];
      req.dev  = latch[15:11];
      req.func = latch[10:8];
      req.regi = latch[7:2];
    end else begin
      if (dw_addr == M1A_DW)                          kind = ACC_M2_REGS;
      else if (dw_addr[DW_ADDR_W-1 -: 4] == M2_PAGE)  kind = ACC_WINDOW;
      win_open = (en[7:4] == 4'hF);
      req.bus  = fwd;
      req.dev  = {1'b0, dw_addr[9:6]};
      req.func = en[3:1];
      req.regi = dw_addr[5:0];
    end
  end
endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
  import cfgport_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] M1_ADDR_PORT = 16'h0CF8,
  parameter logic [IO_ADDR_W-1:0] M1_DATA_PORT = 16'h0CFC,
  parameter logic [IO_ADDR_W-1:0] M2_WIN_BASE  = 16'hC000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mech_sel,
  input  logic                 io_strobe,
  input  logic                 io_wr,
  input  logic [DW_ADDR_W-1:0] io_addr,
  input  logic [BE_W-1:0]      io_be,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic                 io_ready,
  output logic [DATA_W-1:0]    io_rdata,
  output logic                 cfg_req_valid,
  output logic                 cfg_req_write,
  output logic [BUS_W-1:0]     cfg_bus,
  output logic [DEV_W-1:0]     cfg_dev,
  output logic [FUNC_W-1:0]    cfg_func,
  output logic [REG_W-1:0]     cfg_reg,
  output logic [BE_W-1:0]      cfg_be,
  output logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 cfg_ack,
  input  logic [DATA_W-1:0]    cfg_rdata
);
  fsm_e              state_q;
  cfg_req_t          req_q;
  cfg_req_t          dec_req;
  acc_kind_e         dec_kind;
  logic              dec_win_open;
  logic [DATA_W-1:0] latch_q;
  logic [7:0]        en_q;
  logic [7:0]        fwd_q;
  logic [DATA_W-1:0] rdata_q;
  logic              take;

  assign take = (state_q == ST_IDLE) && io_strobe && (dec_kind != ACC_NONE);

  cfgport_decode #(
    .M1_ADDR_PORT(M1_ADDR_PORT),
    .M1_DATA_PORT(M1_DATA_PORT),
    .M2_WIN_BASE (M2_WIN_BASE)
  ) u_decode (
    .mech_sel (mech_sel),
    .dw_addr  (io_addr),
    .wr       (io_wr),
    .be       (io_be),
    .wdata    (io_wdata),
    .latch    (latch_q),
    .en       (en_q),
    .fwd      (fwd_q),
    .kind     (dec_kind),
    .win_open (dec_win_open),
    .req      (dec_req)
  );

  // Only a full-dword write reaches the latch
  cfgport_m1_latch u_m1 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take && dec_kind == ACC_M1_ADDR && io_wr && (io_be == '1)),
    .wr_data (io_wdata),
    .latch_q (latch_q)
  );

  cfgport_m2_regs u_m2 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take && dec_kind == ACC_M2_REGS && io_wr),
    .wr_be   (io_be),
    .wr_data (io_wdata),
    .en_q    (en_q),
    .fwd_q   (fwd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          unique case (dec_kind)
            ACC_M1_ADDR: begin
              rdata_q <= latch_q;
              state_q <= ST_RESP;
            end
            ACC_M2_REGS: begin
              rdata_q <= {8'h00, fwd_q, 8'h00, en_q};
              state_q <= ST_RESP;
            end
            default: begin
              if (dec_win_open) begin
                req_q   <= dec_req;
                state_q <= ST_REQ;
              end else begin
                rdata_q <= '1;
                state_q <= ST_RESP;
              end
            end
          endcase
        end
        ST_REQ: if (cfg_ack) begin
          rdata_q <= req_q.write ? '0 : cfg_rdata;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign io_ready      = (state_q == ST_RESP);
  assign io_rdata      = rdata_q;
  assign cfg_req_valid = (state_q == ST_REQ);
  assign cfg_req_write = req_q.write;
  assign cfg_bus       = req_q.bus;
  assign cfg_dev       = req_q.dev;
  assign cfg_func      = req_q.func;
  assign cfg_reg       = req_q.regi;
  assign cfg_be        = req_q.be;
  assign cfg_wdata     = req_q.wdata;

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    io_ready |=> !io_ready);

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    io_ready |-> !cfg_req_valid);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid && !cfg_ack) |=> (cfg_req_valid && $stable(cfg_bus) &&
      $stable(cfg_dev) && $stable(cfg_func) && $stable(cfg_reg) &&
      $stable(cfg_req_write) && $stable(cfg_wdata) && $stable(cfg_be)));

  a_r7_open_only: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_valid) |-> $past(dec_win_open));

  a_r6_dev_range: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid && mech_sel) |-> !cfg_dev[DEV_W-1]);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (take && dec_kind == ACC_M1_ADDR && !io_wr) |=> ((io_rdata & ~LATCH_KEEP) == '0));
endmodule

// File: tb/cfgport_decoder_tb.sv
module cfgport_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RESP_DLY   = 2;

  logic        clk = 0;
  logic        rst = 1;
  logic        mech_sel = 0;
  logic        io_strobe = 0;
  logic        io_wr = 0;
  logic [13:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ready;
  logic [31:0] io_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int dly = 0;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;
  logic [5:0]  c_reg;
  logic        c_wr;
  logic [3:0]  c_be;
  logic [31:0] c_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_decoder u_dut (
    .clk(clk), .rst(rst), .mech_sel(mech_sel), .io_strobe(io_strobe),
    .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_ready(io_ready), .io_rdata(io_rdata), .cfg_req_valid(cfg_req_valid),
    .cfg_req_write(cfg_req_write), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] pat(input logic [7:0] b, input logic [4:0] d,
                                      input logic [2:0] f, input logic [5:0] r);
    return {8'hA5, b, d, f, r, 2'b00};
  endfunction

  // Configuration target model: acknowledges after RESP_DLY cycles
  always @(negedge clk) begin
    if (cfg_ack) begin
      cfg_ack = 0;
      dly = 0;
    end else if (cfg_req_valid) begin
      if (dly == RESP_DLY) begin
        cfg_ack = 1;
        cfg_rdata = pat(cfg_bus, cfg_dev, cfg_func, cfg_reg);
        c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func; c_reg = cfg_reg;
        c_wr = cfg_req_write; c_be = cfg_be; c_wdata = cfg_wdata;
        req_cnt++;
      end else begin
        dly++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] a, input logic [3:0] be, input logic wr,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic got, output int lat);
    @(negedge clk);
    io_addr = a[15:2]; io_be = be; io_wr = wr; io_wdata = wd; io_strobe = 1;
    got = 0; lat = 0; rd = 'x;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      lat++;
      if (io_ready) begin
        got = 1;
        rd = io_rdata;
        break;
      end
    end
    io_strobe = 0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic got; int lat;
    chk("R1 ready low", {31'b0, io_ready}, 0);
    chk("R1 valid low", {31'b0, cfg_req_valid}, 0);
    mech_sel = 0;
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R1 latch reset", rd, 32'h0);
    mech_sel = 1;
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R1 enable/forward reset", rd, 32'h0);
    mech_sel = 0;
  endtask

  task automatic t_m1_latch();
    logic [31:0] rd; logic got; int lat;
    xfer(16'h0CF8, 4'hF, 1, 32'hFFFF_FFFF, rd, got, lat);
    chk("R9 register write latency", lat, 1);
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R2 all-ones masked", rd, 32'h80FF_FFFC);
    xfer(16'h0CF8, 4'hF, 1, 32'h8012_3457, rd, got, lat);
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R2 readback", rd, 32'h8012_3454);
  endtask

  task automatic t_m1_partial();
    logic [31:0] rd; logic got; int lat;
    xfer(16'h0CF8, 4'hF, 1, 32'h8012_3454, rd, got, lat);
    xfer(16'h0CF8, 4'b0001, 1, 32'h0, rd, got, lat);
    chk("R3 byte write completes", {31'b0, got}, 1);
    xfer(16'h0CFA, 4'b1100, 1, 32'h0, rd, got, lat);
    xfer(16'h0CFB, 4'b1000, 1, 32'h0, rd, got, lat);
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R3 latch unchanged", rd, 32'h8012_3454);
  endtask

  task automatic t_m1_window();
    logic [31:0] rd; logic got; int lat; int n0;
    logic [31:0] la;
    la = 32'h8000_0000 | (32'h12 << 16) | (32'h1D << 11) | (32'h5 << 8) | 32'h3C;
    xfer(16'h0CF8, 4'hF, 1, la, rd, got, lat);
    n0 = req_cnt;
    xfer(16'h0CFC, 4'hF, 0, 0, rd, got, lat);
    chk("R4 one request", req_cnt - n0, 1);
    chk("R4 fields", {c_bus, 3'b0, c_dev, 5'b0, c_func, 2'b0, c_reg},
        {8'h12, 3'b0, 5'h1D, 5'b0, 3'd5, 2'b0, 6'h0F});
    chk("R4 read data", rd, pat(8'h12, 5'h1D, 3'd5, 6'h0F));
    chk("R9 request latency", lat, RESP_DLY + 2);
    xfer(16'h0CFC, 4'b0110, 1, 32'hDEAD_BEEF, rd, got, lat);
    chk("R4 write request", {c_wr, 27'b0, c_be}, {1'b1, 27'b0, 4'b0110});
    chk("R4 write data", c_wdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_m1_closed();
    logic [31:0] rd; logic got; int lat; int n0;
    xfer(16'h0CF8, 4'hF, 1, 32'h0012_3400, rd, got, lat);
    n0 = req_cnt;
    xfer(16'h0CFC, 4'hF, 0, 0, rd, got, lat);
    chk("R7 closed read ones", rd, 32'hFFFF_FFFF);
    chk("R9 closed latency", lat, 1);
    xfer(16'h0CFC, 4'hF, 1, 32'h1234_5678, rd, got, lat);
    chk("R7 no request when closed", req_cnt - n0, 0);
  endtask

  task automatic t_m2_regs();
    logic [31:0] rd; logic got; int lat;
    mech_sel = 1;
    xfer(16'h0CF8, 4'b0001, 1, 32'h0000_00F5, rd, got, lat);
    xfer(16'h0CFA, 4'b0100, 1, 32'h0007_0000, rd, got, lat);
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R5 readback", rd, 32'h0007_00F5);
    xfer(16'h0CF8, 4'b1010, 1, 32'hFFFF_FFFF, rd, got, lat);
    xfer(16'h0CF8, 4'hF, 0, 0, rd, got, lat);
    chk("R5 other lanes ignored", rd, 32'h0007_00F5);
  endtask

  task automatic t_m2_window();
    logic [31:0] rd; logic got; int lat; int n0;
    n0 = req_cnt;
    xfer(16'hCB3C, 4'hF, 0, 0, rd, got, lat);
    chk("R6 one request", req_cnt - n0, 1);
    chk("R6 fields", {c_bus, 3'b0, c_dev, 5'b0, c_func, 2'b0, c_reg},
        {8'h07, 3'b0, 5'h0B, 5'b0, 3'd2, 2'b0, 6'h0F});
    chk("R6 read data", rd, pat(8'h07, 5'h0B, 3'd2, 6'h0F));
    xfer(16'hCF04, 4'b0011, 1, 32'h0BAD_F00D, rd, got, lat);
    chk("R6 write fields", {c_wr, 2'b0, c_dev, 18'b0, c_reg},
        {1'b1, 2'b0, 5'h0F, 18'b0, 6'h01});
    chk("R6 write data", c_wdata, 32'h0BAD_F00D);
  endtask

  task automatic t_m2_closed();
    logic [31:0] rd; logic got; int lat; int n0;
    xfer(16'h0CF8, 4'b0001, 1, 32'h0000_00E5, rd, got, lat);
    n0 = req_cnt;
    xfer(16'hC100, 4'hF, 0, 0, rd, got, lat);
    chk("R7 nibble not F reads ones", rd, 32'hFFFF_FFFF);
    xfer(16'h0CF8, 4'b0001, 1, 32'h0, rd, got, lat);
    xfer(16'hC100, 4'hF, 1, 32'h5555_AAAA, rd, got, lat);
    xfer(16'hC100, 4'hF, 0, 0, rd, got, lat);
    chk("R7 zero enable reads ones", rd, 32'hFFFF_FFFF);
    chk("R7 no paged request", req_cnt - n0, 0);
  endtask

  task automatic t_claim();
    logic [31:0] rd; logic got; int lat; int n0;
    n0 = req_cnt;
    xfer(16'h0CF8, 4'b0001, 1, 32'h0000_00F0, rd, got, lat);
    xfer(16'h0CFC, 4'hF, 0, 0, rd, got, lat);
    chk("R8 latch data port unclaimed in paged", {31'b0, got}, 0);
    mech_sel = 0;
    xfer(16'h0CF8, 4'hF, 1, 32'h8000_0000, rd, got, lat);
    xfer(16'hC100, 4'hF, 0, 0, rd, got, lat);
    chk("R8 paged window unclaimed in latch", {31'b0, got}, 0);
    xfer(16'h0080, 4'hF, 0, 0, rd, got, lat);
    chk("R8 unrelated port unclaimed", {31'b0, got}, 0);
    chk("R8 no request", req_cnt - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_m1_latch();
    t_m1_partial();
    t_m1_window();
    t_m1_closed();
    t_m2_regs();
    t_m2_window();
    t_m2_closed();
    t_claim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule